// File: doc/BRIEF.md
# Serial EEPROM Target Controller for I2C

This block is the protocol core of a byte-addressed serial memory that answers as a target on an I2C bus. It works on SCL and SDA samples that have already been synchronised and filtered, plus one-cycle start and stop event pulses from a separate line monitor. It answers by asserting an open-drain pull-down enable. It decodes the select byte and a two-byte memory address, and it produces the acknowledge bits. It streams write data to an external write engine and fetches read data through a combinational read port.

Writes go through a shared address counter. That counter steps only inside a page while data is written, and it steps across the whole array, wrapping to zero, while data is read. A stop that closes a data phase tells the write engine to commit the bytes it has buffered. While the engine reports that it is busy, the controller refuses its own select code, so a bus master can poll with repeated select bytes until one is acknowledged. A write-lock input blocks data bytes but leaves the select and address phases untouched.

Top module: `eep_i2c_target`

## Requirements
- R1: A select byte is accepted (SDA pulled low during the ninth clock) only when its upper four bits are 1010 and bits 3..1 equal `strap_i[2:0]`. Bit 0 gives the direction: 1 means read and 0 means write. On a mismatch the controller stays released and ignores every later byte until the next start.
- R2: After a write select, two address bytes follow, upper byte first, and each is acknowledged. Only the low `ADDR_W` bits of the 16-bit value are used. Higher bits are ignored.
- R3: Each accepted data byte is acknowledged and appears for one cycle on `wr_byte_o` with its address. A stop that arrives before the second SCL rise after a data byte's acknowledge slot raises `wr_commit_o` for one cycle, in the cycle after `stop_evt`. A stop at any other point commits nothing.
- R4: Successive data bytes in one write go to addresses whose low `PAGE_W` bits count up and wrap. The upper bits stay the same.
- R5: If `wr_lock_i` is high when the second address byte completes, the data bytes of that write are not acknowledged, raise no `wr_byte_o` and lead to no commit. The select and address bytes are still acknowledged.
- R6: While `wr_busy_i` is high when a select byte completes, that select byte is not acknowledged.
- R7: A read select with no preceding address returns the byte at the address counter. The counter then advances by one. After a write it points one past the last byte handled.
- R8: A write select and two address bytes, then a repeated start and a read select, return the byte at the new address.
- R9: Each read byte the master acknowledges is followed by the byte at the next address. A master no-acknowledge ends the read, and the controller then ignores the bus until the next start.
- R10: Reading past address 2^ADDR_W-1 continues at address 0.
- R11: Reads return stored data whatever the level of `wr_lock_i`.
- R12: `sda_oe_o` changes only while SCL is low, except on start and stop. It is released in the ninth slot of every read byte. It is low after reset and after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Filtered SCL level |
| sda_i | input | 1 | Filtered SDA level (bus value) |
| start_evt | input | 1 | One-cycle pulse on a start or repeated start |
| stop_evt | input | 1 | One-cycle pulse on a stop |
| strap_i | input | 3 | Board straps compared with select bits 3..1 |
| wr_lock_i | input | 1 | High blocks data writes |
| wr_busy_i | input | 1 | Write engine is programming |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| wr_byte_o | output | 1 | One-cycle pulse: a data byte is handed to the write engine |
| wr_addr_o | output | ADDR_W | Address of the handed byte |
| wr_data_o | output | 8 | Value of the handed byte |
| wr_commit_o | output | 1 | One-cycle pulse: start programming the buffered bytes |
| rd_addr_o | output | ADDR_W | Read port address (the address counter) |
| rd_data_i | input | 8 | Read port data, combinational from `rd_addr_o` |

## Verification
The bench builds the controller with `ADDR_W` = 12 and `PAGE_W` = 3. With an 8-byte page, a write of three bytes that starts at offset 6 wraps back to the page base, and the byte just above the page can be checked as untouched. With a 4096-byte array, a random read loaded directly at the last address reaches the wrap to address 0 in two bytes. Setting the upper address byte to 0xF1 shows that the ignored high bits have no effect.

// File: rtl/eep_pkg.sv
package eep_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEL,
      ST_AHI,
      ST_ALO,
      ST_WDAT,
      ST_RDAT
   } eep_state_e;

   localparam logic [3:0] DEV_TYPE   = 4'b1010;
   localparam int         BYTE_BITS  = 8;
   localparam int         CNT_W      = 4;
   localparam logic [3:0] SLOT_ACK   = 4'd8;
   localparam logic [3:0] SLOT_DONE  = 4'd9;
endpackage

// File: rtl/eep_scl_edge.sv
module eep_scl_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   output logic rise_o,
   output logic fall_o
);
   logic scl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) scl_q <= 1'b1;
      else        scl_q <= scl_i;
   end

   assign rise_o = scl_i & ~scl_q;
   assign fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/eep_bit_counter.sv
module eep_bit_counter
   import eep_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             fall_i,
   input  logic             sda_i,
   input  logic             restart_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [7:0]       rx_o,
   output logic             byte_end_o,
   output logic             slot_end_o,
   output logic             ack_low_o
);
   logic [CNT_W-1:0] cnt;
   logic [7:0]       rx;
   logic             ack_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         rx      <= '0;
         ack_low <= 1'b0;
      end else if (restart_i) begin
         cnt <= '0;
      end else if (rise_i) begin
         if (cnt < SLOT_ACK) rx <= {rx[6:0], sda_i};
         if (cnt == SLOT_ACK) ack_low <= ~sda_i;
         if (cnt <= SLOT_ACK) cnt <= cnt + 1'b1;
      end else if (fall_i && cnt == SLOT_DONE) begin
         cnt <= '0;
      end
   end

   assign cnt_o      = cnt;
   assign rx_o       = rx;
   assign ack_low_o  = ack_low;
   assign byte_end_o = fall_i && (cnt == SLOT_ACK);
   assign slot_end_o = fall_i && (cnt == SLOT_DONE);
endmodule

// File: rtl/eep_addr_ctr.sv
module eep_addr_ctr #(
   parameter int ADDR_W = 12,
   parameter int PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] load_val_i,
   input  logic              inc_page_i,
   input  logic              inc_lin_i,
   output logic [ADDR_W-1:0] addr_o
);
   logic [ADDR_W-1:0] addr;
   logic [ADDR_W-1:0] nxt_page;

   generate
      if (PAGE_W >= ADDR_W) begin : g_flat
         assign nxt_page = addr + 1'b1;
      end else begin : g_paged
         assign nxt_page = {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          addr <= '0;
      else if (load_i)     addr <= load_val_i;
      else if (inc_page_i) addr <= nxt_page;
      else if (inc_lin_i)  addr <= addr + 1'b1;
   end

   assign addr_o = addr;
endmodule

// File: rtl/eep_i2c_target.sv
module eep_i2c_target
   import eep_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int PAGE_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic              start_evt,
   input  logic              stop_evt,
   input  logic [2:0]        strap_i,
   input  logic              wr_lock_i,
   input  logic              wr_busy_i,
   output logic              sda_oe_o,
   output logic              wr_byte_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [7:0]        wr_data_o,
   output logic              wr_commit_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   input  logic [7:0]        rd_data_i
);
   generate
      if (ADDR_W < 2 || ADDR_W > 16 || PAGE_W < 1 || PAGE_W > ADDR_W) begin : g_bad_cfg
         $error("eep_i2c_target: need 2 <= ADDR_W <= 16 and 1 <= PAGE_W <= ADDR_W");
      end
   endgenerate

   logic             rise, fall;
   logic [CNT_W-1:0] cnt;
   logic [7:0]       rx;
   logic             byte_end, slot_end, ack_low;
   logic             quiet;

   eep_state_e        state;
   logic              rd_sel, lock_l, got_data, load_pend;
   logic [7:0]        tx;
   logic              oe;
   logic              wr_byte, commit;
   logic [ADDR_W-1:0] wr_addr;
   logic [7:0]        wr_data;
   logic [ADDR_W-1:0] addr;
   logic [ADDR_W-1:0] load_val;
   logic              ctr_load, ctr_inc_page, ctr_inc_lin;
   logic              sel_hit;
   logic [2:0]        bit_idx;

   assign quiet   = ~start_evt & ~stop_evt;
   assign sel_hit = (rx[7:4] == DEV_TYPE) && (rx[3:1] == strap_i) && !wr_busy_i;
   assign bit_idx = 3'(4'd7 - cnt);

   eep_scl_edge i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_i  (scl_i),
      .rise_o (rise),
      .fall_o (fall)
   );

   eep_bit_counter i_bits (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (rise),
      .fall_i     (fall),
      .sda_i      (sda_i),
      .restart_i  (start_evt | stop_evt),
      .cnt_o      (cnt),
      .rx_o       (rx),
      .byte_end_o (byte_end),
      .slot_end_o (slot_end),
      .ack_low_o  (ack_low)
   );

   // Upper address byte storage: only the bits the array uses are kept.
   generate
      if (ADDR_W > 8) begin : g_wide
         logic [ADDR_W-9:0] hi_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hi_q <= '0;
            else if (quiet && byte_end && state == ST_AHI) hi_q <= rx[ADDR_W-9:0];
         end
         assign load_val = {hi_q, rx};
      end else begin : g_narrow
         assign load_val = rx[ADDR_W-1:0];
      end
   endgenerate

   assign ctr_load     = quiet && byte_end && state == ST_ALO;
   assign ctr_inc_page = quiet && byte_end && state == ST_WDAT && !lock_l;
   assign ctr_inc_lin  = quiet && slot_end && state == ST_RDAT;

   eep_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) i_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ctr_load),
      .load_val_i (load_val),
      .inc_page_i (ctr_inc_page),
      .inc_lin_i  (ctr_inc_lin),
      .addr_o     (addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         rd_sel    <= 1'b0;
         lock_l    <= 1'b0;
         got_data  <= 1'b0;
         load_pend <= 1'b0;
         tx        <= '0;
         oe        <= 1'b0;
         wr_byte   <= 1'b0;
         wr_addr   <= '0;
         wr_data   <= '0;
         commit    <= 1'b0;
      end else begin
         wr_byte   <= 1'b0;
         commit    <= 1'b0;
         load_pend <= 1'b0;
         if (start_evt) begin
            state    <= ST_SEL;
            oe       <= 1'b0;
            got_data <= 1'b0;
         end else if (stop_evt) begin
            commit   <= (state == ST_WDAT) && got_data && (cnt <= 4'd1);
            state    <= ST_IDLE;
            oe       <= 1'b0;
            got_data <= 1'b0;
         end else begin
            if (load_pend) begin
               tx <= rd_data_i;
               oe <= ~rd_data_i[7];
            end
            if (byte_end) begin
               unique case (state)
                  ST_SEL: begin
                     if (sel_hit) begin
                        oe     <= 1'b1;
                        rd_sel <= rx[0];
                     end else begin
                        state <= ST_IDLE;
                        oe    <= 1'b0;
                     end
                  end
                  ST_AHI: oe <= 1'b1;
                  ST_ALO: begin
                     oe     <= 1'b1;
                     lock_l <= wr_lock_i;
                  end
                  ST_WDAT: begin
                     if (!lock_l) begin
                        oe       <= 1'b1;
                        wr_byte  <= 1'b1;
                        wr_addr  <= addr;
                        wr_data  <= rx;
                        got_data <= 1'b1;
                     end else begin
                        oe <= 1'b0;
                     end
                  end
                  ST_RDAT: oe <= 1'b0;
                  default: oe <= 1'b0;
               endcase
            end
            if (slot_end) begin
               unique case (state)
                  ST_SEL: begin
                     oe <= 1'b0;
                     if (rd_sel) begin
                        state     <= ST_RDAT;
                        load_pend <= 1'b1;
                     end else begin
                        state <= ST_AHI;
                     end
                  end
                  ST_AHI: begin
                     oe    <= 1'b0;
                     state <= ST_ALO;
                  end
                  ST_ALO: begin
                     oe    <= 1'b0;
                     state <= ST_WDAT;
                  end
                  ST_WDAT: oe <= 1'b0;
                  ST_RDAT: begin
                     if (ack_low) load_pend <= 1'b1;
                     else         state     <= ST_IDLE;
                  end
                  default: oe <= 1'b0;
               endcase
            end
            if (fall && state == ST_RDAT && cnt >= 4'd1 && cnt <= 4'd7) begin
               oe <= ~tx[bit_idx];
            end
         end
      end
   end

   assign sda_oe_o    = oe;
   assign wr_byte_o   = wr_byte;
   assign wr_addr_o   = wr_addr;
   assign wr_data_o   = wr_data;
   assign wr_commit_o = commit;
   assign rd_addr_o   = addr;
endmodule

// File: rtl/eep_checker.sv
module eep_checker (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic start_evt,
   input logic stop_evt,
   input logic sda_oe_o,
   input logic wr_byte_o,
   input logic wr_commit_o
);
   // R12
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !sda_oe_o);

   // R12
   oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((sda_oe_o != $past(sda_oe_o)) && !$past(start_evt) && !$past(stop_evt))
         |-> !$past(scl_i));

   // R3
   commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit_o |-> $past(stop_evt));

   // R3
   byte_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_byte_o |-> sda_oe_o);

   // R3
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_byte_o, wr_commit_o}));
endmodule

bind eep_i2c_target eep_checker i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .scl_i       (scl_i),
   .start_evt   (start_evt),
   .stop_evt    (stop_evt),
   .sda_oe_o    (sda_oe_o),
   .wr_byte_o   (wr_byte_o),
   .wr_commit_o (wr_commit_o)
);

// File: tb/test_eep_i2c_target.sv
module test_eep_i2c_target;
   localparam int AW = 12;
   localparam int PW = 3;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1, sda_m = 1'b1;
   logic start_evt = 1'b0, stop_evt = 1'b0;
   logic [2:0] strap = 3'b000;
   logic lock = 1'b0, force_busy = 1'b0;
   logic sda_oe, wr_byte, wr_commit;
   logic [AW-1:0] wr_addr, rd_addr;
   logic [7:0] wr_data, rd_data;
   logic sda_bus, busy;

   logic [7:0] mem [DEPTH];
   logic [AW-1:0] pa [16];
   logic [7:0] pd [16];
   int pn = 0;
   int busy_cnt = 0;
   int n_commit = 0;
   int n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;

   assign sda_bus = sda_m & ~sda_oe;
   assign busy    = (busy_cnt != 0) | force_busy;
   assign rd_data = mem[rd_addr];

   eep_i2c_target #(.ADDR_W(AW), .PAGE_W(PW)) i_eep_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .start_evt(start_evt), .stop_evt(stop_evt), .strap_i(strap),
      .wr_lock_i(lock), .wr_busy_i(busy), .sda_oe_o(sda_oe),
      .wr_byte_o(wr_byte), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .wr_commit_o(wr_commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
   );

   function automatic logic [7:0] init_val(int a);
      return 8'(a * 37 + 11);
   endfunction

   // Write engine model: buffers handed bytes, programs them on commit.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= init_val(i);
         pn <= 0;
         busy_cnt <= 0;
      end else begin
         if (wr_byte && pn < 16) begin
            pa[pn] <= wr_addr;
            pd[pn] <= wr_data;
            pn <= pn + 1;
         end
         if (wr_commit) begin
            for (int k = 0; k < pn; k++) mem[pa[k]] <= pd[k];
            pn <= 0;
            busy_cnt <= 300;
            n_commit <= n_commit + 1;
         end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bit_out(input logic b);
      scl = 1'b0; tick(2); sda_m = b; tick(2); scl = 1'b1; tick(4);
   endtask

   task automatic send_byte(input logic [7:0] d, output logic ack);
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      scl = 1'b0; tick(2); sda_m = 1'b1; tick(2); scl = 1'b1; tick(1);
      ack = ~sda_bus; tick(3);
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] d, output logic rel);
      for (int i = 7; i >= 0; i--) begin
         scl = 1'b0; tick(2); sda_m = 1'b1; tick(2); scl = 1'b1; tick(1);
         d[i] = sda_bus; tick(3);
      end
      scl = 1'b0; tick(2); sda_m = ~mack; tick(2); scl = 1'b1; tick(1);
      rel = ~sda_oe; tick(3);
   endtask

   task automatic do_start;
      scl = 1'b0; tick(2); sda_m = 1'b1; tick(2); scl = 1'b1; tick(2);
      sda_m = 1'b0; start_evt = 1'b1; tick(1); start_evt = 1'b0; tick(2);
   endtask

   task automatic do_stop;
      scl = 1'b0; tick(2); sda_m = 1'b0; tick(2); scl = 1'b1; tick(2);
      sda_m = 1'b1; stop_evt = 1'b1; tick(1); stop_evt = 1'b0; tick(4);
   endtask

   task automatic wait_ready;
      while (busy) tick(1);
      tick(2);
   endtask

   // Random-read setup: write select, address, repeated start, read select.
   task automatic set_read(input logic [15:0] a, output logic ok);
      logic k0, k1, k2, k3;
      do_start; send_byte(8'hA0, k0); send_byte(a[15:8], k1); send_byte(a[7:0], k2);
      do_start; send_byte(8'hA1, k3);
      ok = k0 & k1 & k2 & k3;
   endtask

   task automatic finish_up;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   // {expect_ack, busy, strap[2:0], select[7:0]}
   localparam logic [12:0] SEL_TAB [7] = '{
      {1'b1, 1'b0, 3'b000, 8'hA0},
      {1'b1, 1'b0, 3'b011, 8'hA6},
      {1'b0, 1'b0, 3'b010, 8'hA6},
      {1'b0, 1'b0, 3'b000, 8'hB0},
      {1'b1, 1'b0, 3'b000, 8'hA1},
      {1'b0, 1'b1, 3'b000, 8'hA0},
      {1'b1, 1'b0, 3'b111, 8'hAE}
   };

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_up;
   end

   initial begin
      logic ack, rel, ok;
      logic [7:0] d;
      int c0;
      tick(5);
      check("R12 reset oe", int'(sda_oe), 0);
      check("R3 reset byte pulse", int'(wr_byte), 0);
      check("R3 reset commit", int'(wr_commit), 0);
      rst_n = 1'b1;
      tick(5);

      // Select decode table (R1, R6)
      for (int t = 0; t < 7; t++) begin
         strap = SEL_TAB[t][10:8];
         force_busy = SEL_TAB[t][11];
         do_start;
         send_byte(SEL_TAB[t][7:0], ack);
         check(SEL_TAB[t][11] ? "R6 busy select" : "R1 select decode", int'(ack), int'(SEL_TAB[t][12]));
         do_stop;
         force_busy = 1'b0;
      end
      strap = 3'b000;

      // R1: after a mismatch later bytes are ignored
      do_start; send_byte(8'hA2, ack);
      check("R1 mismatch nack", int'(ack), 0);
      send_byte(8'hA0, ack);
      check("R1 ignored after mismatch", int'(ack), 0);
      do_stop;

      // Byte write (R2, R3)
      do_start; send_byte(8'hA0, ack);
      send_byte(8'h01, ack); check("R2 addr hi ack", int'(ack), 1);
      send_byte(8'h23, ack); check("R2 addr lo ack", int'(ack), 1);
      send_byte(8'hA5, ack); check("R3 data ack", int'(ack), 1);
      do_stop;
      check("R3 commit count", n_commit, 1);
      check("R3 stored", int'(mem[12'h123]), 8'hA5);

      // R6: polling while busy
      do_start; send_byte(8'hA0, ack);
      check("R6 busy poll nack", int'(ack), 0);
      do_stop;
      wait_ready;
      do_start; send_byte(8'hA0, ack);
      check("R6 ready poll ack", int'(ack), 1);
      do_stop;

      // R7: current-address reads
      do_start; send_byte(8'hA1, ack);
      recv_byte(1'b0, d, rel);
      check("R7 current read", int'(d), int'(init_val(12'h124)));
      do_stop;
      do_start; send_byte(8'hA1, ack);
      recv_byte(1'b0, d, rel);
      check("R7 counter advanced", int'(d), int'(init_val(12'h125)));
      do_stop;

      // R8/R9/R12: random then sequential read
      set_read(16'h0123, ok);
      check("R8 random read acks", int'(ok), 1);
      recv_byte(1'b1, d, rel);
      check("R8 random read data", int'(d), 8'hA5);
      check("R12 release in ack slot", int'(rel), 1);
      recv_byte(1'b0, d, rel);
      check("R9 sequential next", int'(d), int'(init_val(12'h124)));
      check("R12 release on last", int'(rel), 1);
      recv_byte(1'b0, d, rel);
      check("R9 standby after nack", int'(d), 8'hFF);
      do_stop;

      // R2: upper address bits ignored
      set_read(16'hF123, ok);
      recv_byte(1'b0, d, rel);
      check("R2 upper bits ignored", int'(d), 8'hA5);
      do_stop;

      // R4: page write wraps inside an 8-byte page
      do_start; send_byte(8'hA0, ack); send_byte(8'h02, ack); send_byte(8'hC6, ack);
      send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
      do_stop;
      wait_ready;
      check("R4 page byte 0", int'(mem[12'h2C6]), 8'h11);
      check("R4 page byte 1", int'(mem[12'h2C7]), 8'h22);
      check("R4 page wrap", int'(mem[12'h2C0]), 8'h33);
      check("R4 next page untouched", int'(mem[12'h2C8]), int'(init_val(12'h2C8)));

      // R5: write lock
      lock = 1'b1;
      c0 = n_commit;
      do_start; send_byte(8'hA0, ack);
      check("R5 select ack under lock", int'(ack), 1);
      send_byte(8'h00, ack); send_byte(8'h50, ack);
      check("R5 addr ack under lock", int'(ack), 1);
      send_byte(8'h77, ack);
      check("R5 data nack under lock", int'(ack), 0);
      do_stop;
      tick(4);
      check("R5 no commit", n_commit, c0);
      check("R5 memory kept", int'(mem[12'h050]), int'(init_val(12'h050)));

      // R11: read with lock high
      set_read(16'h0050, ok);
      check("R11 read acks under lock", int'(ok), 1);
      recv_byte(1'b0, d, rel);
      check("R11 read under lock", int'(d), int'(init_val(12'h050)));
      do_stop;
      lock = 1'b0;

      // R10: rollover
      set_read(16'h0FFF, ok);
      recv_byte(1'b1, d, rel);
      check("R10 last address", int'(d), int'(init_val(12'hFFF)));
      recv_byte(1'b0, d, rel);
      check("R10 rollover to 0", int'(d), int'(init_val(0)));
      do_stop;

      // R3: stop in the middle of a data byte commits nothing
      c0 = n_commit;
      do_start; send_byte(8'hA0, ack); send_byte(8'h03, ack); send_byte(8'h00, ack);
      for (int i = 0; i < 4; i++) bit_out(1'b0);
      do_stop;
      tick(4);
      check("R3 mid-byte stop no commit", n_commit, c0);
      check("R3 mid-byte memory kept", int'(mem[12'h300]), int'(init_val(12'h300)));
      check("R12 released after stop", int'(sda_oe), 0);

      finish_up;
   end
endmodule